// File: doc/BRIEF.md
# Serial display command decoder

This block sits behind a serial byte receiver in a small graphics display controller. Each received byte arrives with a one-cycle valid strobe and a select level. A high select routes the byte to the pixel write path. A low select feeds it to a command parser. The parser treats the first command byte as an opcode and looks up how many parameter bytes follow, from zero to eight. It then collects those bytes and runs the command once the last one has arrived.

Only three kinds of command change state: the column window, the row window and the remap value. Window coordinates wrap modulo the column count (64) and the row count (80). A one-cycle load pulse tells the address generator downstream to reload its current position from the new start value. All other recognised opcodes are consumed along with their parameters and have no effect. Opcode byte 0xFF is dropped silently. Any other unrecognised opcode is dropped and raises a one-cycle error pulse.

Top module: `disp_cmd_decoder`

## Requirements
- R1: A byte taken with `dc_sel` = 1 appears on `pix_data` with `pix_we` = 1 in the cycle after it is taken, for exactly one cycle. It never causes a load pulse or an error, and it does not disturb command parsing.
- R2: Opcode 0x15 followed by parameters A then B sets `col_start` = A mod 64 and `col_end` = B mod 64. `col_load` is high for one cycle, in the cycle after B is taken. Nothing changes after A alone.
- R3: Opcode 0x75 followed by A then B sets `row_start` = A mod 80 and `row_end` = B mod 80. `row_load` is high for one cycle after B.
- R4: Opcode 0xA0 followed by one byte stores that byte in `remap`. The new value is visible in the cycle after the byte is taken.
- R5: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each swallow exactly one parameter byte with no effect. The byte after that parameter is parsed as an opcode.
- R6: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 take no parameters and have no effect. The next command byte is an opcode.
- R7: Opcode 0xB8 swallows exactly eight parameter byte values of any kind with no effect.
- R8: The byte 0xFF in opcode position is discarded without an error. The parser keeps waiting for an opcode.
- R9: Any other opcode not listed in R2 to R8 raises `bad_op` for one cycle, in the cycle after it is taken. The parser then waits for an opcode again.
- R10: Data bytes arriving in the middle of a command leave the partial command pending. Later command bytes complete it.
- R11: A synchronous active-high `rst` gives the following state: `col_start` = 0, `col_end` = 63, `row_start` = 0, `row_end` = 79, `remap` = 0, and all pulses low. It also drops any partly collected command, so the next command byte is an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` is valid |
| byte_in | input | 8 | Received byte |
| dc_sel | input | 1 | 1 = pixel data, 0 = command byte |
| pix_we | output | 1 | Pixel byte write strobe |
| pix_data | output | 8 | Pixel byte for the framebuffer |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| col_load | output | 1 | One-cycle pulse: column window written |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| row_load | output | 1 | One-cycle pulse: row window written |
| remap | output | 8 | Remap setting |
| bad_op | output | 1 | One-cycle pulse: unknown opcode dropped |

## Verification
The parser is driven with command streams in which each opcode class is followed by a probe command (0xA0 with a distinct value). A wrong parameter count then shows up as a misread probe. Window parameters above the modulus check the wrap separately for columns and rows. Data bytes placed between the parameters of a command separate "pending survives" from "pending dropped". A reset issued between an opcode and its parameters shows whether the partial command is really discarded.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam int BYTE_W      = 8;
    localparam int MAX_PARAMS  = 8;
    localparam int PCNT_W      = $clog2(MAX_PARAMS + 1);

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_COL   = 2'd1,
        ACT_ROW   = 2'd2,
        ACT_REMAP = 2'd3
    } act_kind_e;

    typedef struct packed {
        logic               known;
        logic               drop;
        logic [PCNT_W-1:0]  nparams;
        act_kind_e          kind;
    } op_info_t;

    typedef struct packed {
        logic               valid;
        act_kind_e          kind;
        logic [BYTE_W-1:0]  p0;
        logic [BYTE_W-1:0]  p1;
    } cmd_exec_t;

    function automatic op_info_t op_decode(input logic [BYTE_W-1:0] op);
        op_info_t r;
        r.known   = 1'b1;
        r.drop    = 1'b0;
        r.nparams = '0;
        r.kind    = ACT_NONE;
        case (op)
            8'h15: begin r.nparams = PCNT_W'(2); r.kind = ACT_COL;   end
            8'h75: begin r.nparams = PCNT_W'(2); r.kind = ACT_ROW;   end
            8'hA0: begin r.nparams = PCNT_W'(1); r.kind = ACT_REMAP; end
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                r.nparams = PCNT_W'(1);
            8'h84, 8'h85, 8'h86,
            8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3:
                r.nparams = '0;
            8'hB8:
                r.nparams = PCNT_W'(MAX_PARAMS);
            8'hFF:
                r.drop = 1'b1;
            default:
                r.known = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/disp_op_lookup.sv
module disp_op_lookup
    import disp_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    always_comb begin
        info = op_decode(opcode);
    end
endmodule

// File: rtl/disp_cmd_collect.sv
module disp_cmd_collect
    import disp_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_vld,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  op_info_t          info,
    output cmd_exec_t         exec,
    output logic              bad_op
);
    typedef enum logic {PS_OPCODE, PS_PARAMS} parse_state_e;

    parse_state_e       state;
    logic [PCNT_W-1:0]  cnt;
    logic [PCNT_W-1:0]  need;
    act_kind_e          kind;
    logic [BYTE_W-1:0]  first_p;
    logic               last_param;

    assign last_param = (cnt + PCNT_W'(1)) == need;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_OPCODE;
            cnt     <= '0;
            need    <= '0;
            kind    <= ACT_NONE;
            first_p <= '0;
            bad_op  <= 1'b0;
        end else begin
            bad_op <= 1'b0;
            if (cmd_vld) begin
                case (state)
                    PS_OPCODE: begin
                        if (info.drop) begin
                            state <= PS_OPCODE;
                        end else if (!info.known) begin
                            bad_op <= 1'b1;
                        end else if (info.nparams != '0) begin
                            state <= PS_PARAMS;
                            need  <= info.nparams;
                            kind  <= info.kind;
                            cnt   <= '0;
                        end
                    end
                    PS_PARAMS: begin
                        if (cnt == '0) first_p <= cmd_byte;
                        if (last_param) begin
                            state <= PS_OPCODE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + PCNT_W'(1);
                        end
                    end
                    default: state <= PS_OPCODE;
                endcase
            end
        end
    end

    always_comb begin
        exec.valid = cmd_vld && (state == PS_PARAMS) && last_param;
        exec.kind  = kind;
        exec.p0    = (cnt == '0) ? cmd_byte : first_p;
        exec.p1    = cmd_byte;
    end
endmodule

// File: rtl/disp_window_regs.sv
module disp_window_regs
    import disp_cmd_pkg::*;
#(
    parameter int COL_COUNT = 64,
    parameter int ROW_COUNT = 80,
    localparam int COL_W = $clog2(COL_COUNT),
    localparam int ROW_W = $clog2(ROW_COUNT)
)(
    input  logic               clk,
    input  logic               rst,
    input  cmd_exec_t          exec,
    output logic [COL_W-1:0]   col_start,
    output logic [COL_W-1:0]   col_end,
    output logic               col_load,
    output logic [ROW_W-1:0]   row_start,
    output logic [ROW_W-1:0]   row_end,
    output logic               row_load,
    output logic [BYTE_W-1:0]  remap
);
    function automatic logic [COL_W-1:0] wrap_col(input logic [BYTE_W-1:0] v);
        return COL_W'(32'(v) % COL_COUNT);
    endfunction

    function automatic logic [ROW_W-1:0] wrap_row(input logic [BYTE_W-1:0] v);
        return ROW_W'(32'(v) % ROW_COUNT);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            col_start <= '0;
            col_end   <= COL_W'(COL_COUNT - 1);
            row_start <= '0;
            row_end   <= ROW_W'(ROW_COUNT - 1);
            remap     <= '0;
            col_load  <= 1'b0;
            row_load  <= 1'b0;
        end else begin
            col_load <= 1'b0;
            row_load <= 1'b0;
            if (exec.valid) begin
                case (exec.kind)
                    ACT_COL: begin
                        col_start <= wrap_col(exec.p0);
                        col_end   <= wrap_col(exec.p1);
                        col_load  <= 1'b1;
                    end
                    ACT_ROW: begin
                        row_start <= wrap_row(exec.p0);
                        row_end   <= wrap_row(exec.p1);
                        row_load  <= 1'b1;
                    end
                    ACT_REMAP: remap <= exec.p0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/disp_pixel_port.sv
module disp_pixel_port
    import disp_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_vld,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              pix_we,
    output logic [BYTE_W-1:0] pix_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_we   <= 1'b0;
            pix_data <= '0;
        end else begin
            pix_we <= data_vld;
            if (data_vld) pix_data <= data_byte;
        end
    end
endmodule

// File: rtl/disp_cmd_decoder.sv
module disp_cmd_decoder
    import disp_cmd_pkg::*;
#(
    parameter int COL_COUNT = 64,
    parameter int ROW_COUNT = 80,
    localparam int COL_W = $clog2(COL_COUNT),
    localparam int ROW_W = $clog2(ROW_COUNT)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               dc_sel,
    output logic               pix_we,
    output logic [BYTE_W-1:0]  pix_data,
    output logic [COL_W-1:0]   col_start,
    output logic [COL_W-1:0]   col_end,
    output logic               col_load,
    output logic [ROW_W-1:0]   row_start,
    output logic [ROW_W-1:0]   row_end,
    output logic               row_load,
    output logic [BYTE_W-1:0]  remap,
    output logic               bad_op
);
    logic      cmd_vld;
    logic      data_vld;
    op_info_t  info;
    cmd_exec_t exec;

    assign cmd_vld  = byte_vld && !dc_sel;
    assign data_vld = byte_vld &&  dc_sel;

    disp_op_lookup u_lookup (
        .opcode (byte_in),
        .info   (info)
    );

    disp_cmd_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .cmd_vld  (cmd_vld),
        .cmd_byte (byte_in),
        .info     (info),
        .exec     (exec),
        .bad_op   (bad_op)
    );

    disp_window_regs #(
        .COL_COUNT (COL_COUNT),
        .ROW_COUNT (ROW_COUNT)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .exec      (exec),
        .col_start (col_start),
        .col_end   (col_end),
        .col_load  (col_load),
        .row_start (row_start),
        .row_end   (row_end),
        .row_load  (row_load),
        .remap     (remap)
    );

    disp_pixel_port u_pix (
        .clk       (clk),
        .rst       (rst),
        .data_vld  (data_vld),
        .data_byte (byte_in),
        .pix_we    (pix_we),
        .pix_data  (pix_data)
    );
endmodule

// File: rtl/disp_cmd_checker.sv
module disp_cmd_checker #(
    parameter int COL_COUNT = 64,
    parameter int ROW_COUNT = 80,
    localparam int COL_W = $clog2(COL_COUNT),
    localparam int ROW_W = $clog2(ROW_COUNT)
)(
    input logic             clk,
    input logic             rst,
    input logic             byte_vld,
    input logic [7:0]       byte_in,
    input logic             dc_sel,
    input logic             pix_we,
    input logic [7:0]       pix_data,
    input logic [COL_W-1:0] col_start,
    input logic [COL_W-1:0] col_end,
    input logic             col_load,
    input logic [ROW_W-1:0] row_start,
    input logic [ROW_W-1:0] row_end,
    input logic             row_load,
    input logic [7:0]       remap,
    input logic             bad_op
);
    a_r1_pix_from_data: assert property (@(posedge clk) disable iff (rst)
        pix_we |-> $past(byte_vld && dc_sel));

    a_r1_pix_value: assert property (@(posedge clk) disable iff (rst)
        pix_we |-> pix_data == $past(byte_in));

    a_r1_data_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        $past(byte_vld && dc_sel) |-> !col_load && !row_load && !bad_op);

    a_r2_col_change_flagged: assert property (@(posedge clk) disable iff (rst)
        (col_start != $past(col_start) || col_end != $past(col_end)) |-> col_load);

    a_r3_row_change_flagged: assert property (@(posedge clk) disable iff (rst)
        (row_start != $past(row_start) || row_end != $past(row_end)) |-> row_load);

    a_r3_row_in_range: assert property (@(posedge clk) disable iff (rst)
        (32'(row_start) < ROW_COUNT) && (32'(row_end) < ROW_COUNT));

    a_r4_remap_from_cmd: assert property (@(posedge clk) disable iff (rst)
        (remap != $past(remap)) |-> $past(byte_vld && !dc_sel) && remap == $past(byte_in));

    a_r9_err_from_cmd: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> $past(byte_vld && !dc_sel));

    a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({col_load, row_load, bad_op}));
endmodule

bind disp_cmd_decoder disp_cmd_checker #(
    .COL_COUNT (COL_COUNT),
    .ROW_COUNT (ROW_COUNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .dc_sel    (dc_sel),
    .pix_we    (pix_we),
    .pix_data  (pix_data),
    .col_start (col_start),
    .col_end   (col_end),
    .col_load  (col_load),
    .row_start (row_start),
    .row_end   (row_end),
    .row_load  (row_load),
    .remap     (remap),
    .bad_op    (bad_op)
);

// File: tb/sim_disp_cmd_decoder.sv
`timescale 1ns/1ps
module sim_disp_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       dc_sel = 1'b0;
    logic       pix_we;
    logic [7:0] pix_data;
    logic [5:0] col_start, col_end;
    logic [6:0] row_start, row_end;
    logic       col_load, row_load, bad_op;
    logic [7:0] remap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    disp_cmd_decoder u0 (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .dc_sel(dc_sel), .pix_we(pix_we), .pix_data(pix_data),
        .col_start(col_start), .col_end(col_end), .col_load(col_load),
        .row_start(row_start), .row_end(row_end), .row_load(row_load),
        .remap(remap), .bad_op(bad_op)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Drive one byte for one cycle; returns at the negedge after the sampling edge.
    task automatic send(input logic dc, input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1; dc_sel = dc; byte_in = b;
        @(negedge clk);
        byte_vld = 1'b0; dc_sel = 1'b0; byte_in = 8'h00;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R11 col_start", col_start, 0);
        chk("R11 col_end", col_end, 63);
        chk("R11 row_start", row_start, 0);
        chk("R11 row_end", row_end, 79);
        chk("R11 remap", remap, 0);
        chk("R11 pulses", {col_load, row_load, bad_op, pix_we}, 0);
    endtask

    task automatic t_data_path();
        send(1'b1, 8'h5A);
        chk("R1 pix_we", pix_we, 1);
        chk("R1 pix_data", pix_data, 8'h5A);
        chk("R1 no load", {col_load, row_load, bad_op}, 0);
        idle_cycle();
        chk("R1 pix_we one cycle", pix_we, 0);
    endtask

    task automatic t_col_window();
        send(1'b0, 8'h15);
        send(1'b0, 8'h47);
        chk("R2 no load after first param", col_load, 0);
        chk("R2 start held after first param", col_start, 0);
        send(1'b0, 8'hC5);
        chk("R2 col_start mod 64", col_start, 7);
        chk("R2 col_end mod 64", col_end, 5);
        chk("R2 col_load", col_load, 1);
        idle_cycle();
        chk("R2 col_load one cycle", col_load, 0);
    endtask

    task automatic t_row_window();
        send(1'b0, 8'h75);
        send(1'b0, 8'hA3);
        send(1'b0, 8'h4F);
        chk("R3 row_start mod 80", row_start, 3);
        chk("R3 row_end", row_end, 79);
        chk("R3 row_load", row_load, 1);
        idle_cycle();
        chk("R3 row_load one cycle", row_load, 0);
        send(1'b0, 8'h75);
        send(1'b0, 8'h50);
        send(1'b0, 8'h9F);
        chk("R3 row_start 80 wraps", row_start, 0);
        chk("R3 row_end 159 wraps", row_end, 79);
    endtask

    task automatic t_remap();
        send(1'b0, 8'hA0);
        send(1'b0, 8'h52);
        chk("R4 remap", remap, 8'h52);
        chk("R4 no window load", {col_load, row_load}, 0);
    endtask

    task automatic t_one_param_ignored();
        send(1'b0, 8'h81);
        send(1'b0, 8'h15);
        send(1'b0, 8'hA0);
        send(1'b0, 8'h11);
        chk("R5 param swallowed, probe remap", remap, 8'h11);
        chk("R5 column untouched", col_start, 7);
        send(1'b0, 8'hBF);
        send(1'b0, 8'h75);
        send(1'b0, 8'hA0);
        send(1'b0, 8'h12);
        chk("R5 second opcode probe remap", remap, 8'h12);
        chk("R5 row untouched", row_start, 0);
    endtask

    task automatic t_zero_param();
        send(1'b0, 8'hA5);
        send(1'b0, 8'hE3);
        send(1'b0, 8'hA0);
        send(1'b0, 8'h22);
        chk("R6 zero-param then remap", remap, 8'h22);
        chk("R6 no error", bad_op, 0);
    endtask

    task automatic t_eight_param();
        logic [7:0] seq [8] = '{8'h15, 8'h01, 8'h02, 8'h75, 8'h03, 8'h04, 8'hA0, 8'h05};
        send(1'b0, 8'hB8);
        for (int i = 0; i < 8; i++) send(1'b0, seq[i]);
        chk("R7 params had no effect remap", remap, 8'h22);
        chk("R7 col untouched", col_start, 7);
        chk("R7 row untouched", row_end, 79);
        send(1'b0, 8'hA0);
        send(1'b0, 8'h33);
        chk("R7 next byte is opcode", remap, 8'h33);
    endtask

    task automatic t_ff_drop();
        send(1'b0, 8'hFF);
        chk("R8 no error on 0xFF", bad_op, 0);
        send(1'b0, 8'hA0);
        send(1'b0, 8'h44);
        chk("R8 parser idle after 0xFF", remap, 8'h44);
    endtask

    task automatic t_unknown();
        send(1'b0, 8'h00);
        chk("R9 bad_op pulse", bad_op, 1);
        idle_cycle();
        chk("R9 bad_op one cycle", bad_op, 0);
        send(1'b0, 8'hA0);
        send(1'b0, 8'h55);
        chk("R9 parser idle after unknown", remap, 8'h55);
    endtask

    task automatic t_mid_command_data();
        send(1'b0, 8'h15);
        send(1'b0, 8'h02);
        send(1'b1, 8'h99);
        chk("R10 data passed", pix_data, 8'h99);
        chk("R10 no load yet", col_load, 0);
        send(1'b0, 8'h09);
        chk("R10 col_start completed", col_start, 2);
        chk("R10 col_end completed", col_end, 9);
        chk("R10 col_load", col_load, 1);
    endtask

    task automatic t_reset_mid_command();
        send(1'b0, 8'h75);
        send(1'b0, 8'h05);
        do_reset();
        t_reset_state();
        send(1'b0, 8'hA0);
        send(1'b0, 8'h66);
        chk("R11 pending dropped, remap", remap, 8'h66);
        chk("R11 pending dropped, no row load", row_load, 0);
        chk("R11 row_end kept", row_end, 79);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_cycle();
        t_reset_state();
        t_data_path();
        t_col_window();
        t_row_window();
        t_remap();
        t_one_param_ignored();
        t_zero_param();
        t_eight_param();
        t_ff_drop();
        t_unknown();
        t_mid_command_data();
        t_reset_mid_command();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule